// File: doc/BRIEF.md
# Cascadable Nine-Tap FIR Filter

The filter takes one signed 12-bit integer sample on every clock. It moves the samples along a nine-stage tap line and multiplies each tap by its own signed 10-bit fractional coefficient. It then sums the nine products together with a 16-bit cascade word and gives out one rounded 16-bit result per clock. Both the cascade input and the output use 12.4 fixed point, meaning 12 integer bits and 4 fraction bits. This lets the output of one filter drive the cascade input of the next. A longer filter can be built in this way from several instances with no loss of throughput.

Coefficients are written like a small register file, one slot per clock, using a write strobe, an address and a data word. The output is rounded at its own LSB by adding half an LSB. A user who wants a coarser result can hold the cascade-input bit just below the chosen LSB at 1 and ignore the output bits below that LSB. An output that goes past the 16-bit range wraps round.

Top module: `casc_fir9`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it goes high, `cascade_out` is 0. Reset clears every coefficient slot, every tap and every pipeline stage.
- R2: A clock edge with `coef_we`=1 and `coef_addr` in 0..8 stores `coef_wdata` into that slot. The stored word is a signed coefficient of value raw/512. Slot 0 weights the newest sample and slot 8 weights the oldest.
- R3: A write with `coef_addr` in 9..15 changes no coefficient, so a later impulse response is the same as before the write.
- R4: A sample taken at edge k shifts one tap per clock. Tap i contributes to the output seen after edge k+5+i. An impulse therefore gives a nine-sample response over edges k+5..k+13, with its centre at k+9, and 0 outside that range.
- R5: A value on `cascade_in` at edge m is added into the output seen after edge m+4. With all coefficients zero it appears unchanged there, and only there.
- R6: The output after edge n is floor((S + 32·c + 16) / 32) mod 2^16. Here S is the sum over i of raw_coef[i]·x(n−5−i), and c is the signed cascade word taken at edge n−4. In other words it is 12.4 rounding by half an LSB, with ties going upward.
- R7: Hold cascade-input bit 3 (weight 1/2) at 1 and use only `cascade_out[15:4]`. Those bits then give the sum of products rounded by half an LSB to a whole integer.
- R8: A result outside the signed 16-bit range wraps modulo 2^16. It does not saturate.
- R9: A new result comes out on every clock, so an unbroken stream of random samples and cascade words matches R6 on every cycle.
- R10: Feed instance A's `cascade_out` into instance B's `cascade_in`. B's output then equals B's own sum of products plus A's output from five clocks before, rounded by R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Coefficient slot; 0..8 are valid |
| coef_wdata | input | 10 | Signed coefficient, 9 fraction bits |
| sample_in | input | 12 | Signed integer sample, taken every clock |
| cascade_in | input | 16 | Signed 12.4 word added into the sum |
| cascade_out | output | 16 | Signed 12.4 rounded result |

## Verification
A scaled impulse shows the order of the coefficient slots and the five-to-thirteen-cycle response window. A single cascade pulse, sent while all coefficients are zero, measures the four-cycle cascade path on its own. Samples placed just below, on and just above the half-LSB threshold tell round-half-up apart from truncation and from rounding toward zero. A half-weight cascade bit shows the coarser rounding. Full-scale constants force the result to wrap, and long random streams through one instance and through two chained instances check full throughput and the cascade summation on every cycle.

// File: rtl/casc_fir9_pkg.sv
package casc_fir9_pkg;
   // clock edges from sample capture to the output register
   localparam int LAT_SAMPLE  = 5;
   // clock edges from cascade capture to the output register
   localparam int LAT_CASCADE = 4;

   // accumulator width that holds every product, the sum growth and the cascade word
   function automatic int acc_width(input int prod_w, input int taps,
                                    input int cas_w, input int align);
      int a;
      int b;
      a = prod_w + $clog2(taps) + 1;
      b = cas_w + align + 1;
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/casc_fir9_coef_bank.sv
module casc_fir9_coef_bank #(
   parameter int TAPS   = 9,
   parameter int COEF_W = 10,
   parameter int ADDR_W = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [COEF_W-1:0]            wr_data,
   output logic [TAPS-1:0][COEF_W-1:0]  coef_q,
   output logic                         coef_zero
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(TAPS - 1);

   if ((1 << ADDR_W) < TAPS) begin : g_bad_addr
      $error("coefficient address too narrow for the tap count");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coef_q <= '0;
      end else if (wr_en) begin
         for (int t = 0; t < TAPS; t++) begin
            if (wr_addr == ADDR_W'(t)) coef_q[t] <= wr_data;
         end
      end
   end

   assign coef_zero = (coef_q == '0);

   // R3: a write to an address outside the slot range changes nothing
   assert_far_addr_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr > LAST_ADDR)) |=> $stable(coef_q));

   // R2: an in-range write lands in the addressed slot
   assert_coef_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr <= LAST_ADDR)) |=> (coef_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/casc_fir9_tapline.sv
module casc_fir9_tapline #(
   parameter int TAPS   = 9,
   parameter int DATA_W = 12,
   parameter int COEF_W = 10,
   parameter int PROD_W = DATA_W + COEF_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [DATA_W-1:0]            sample_in,
   input  logic [TAPS-1:0][COEF_W-1:0]  coef,
   output logic [TAPS-1:0][PROD_W-1:0]  prod_q
);
   logic [TAPS-1:0][DATA_W-1:0] tap_q;
   logic signed [PROD_W-1:0]    mul [TAPS];

   if (PROD_W < DATA_W + COEF_W) begin : g_bad_prod
      $error("product width cannot hold a full product");
   end

   // tap 0 is the input register; each edge moves every sample one tap on
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_q <= '0;
      end else begin
         tap_q[0] <= sample_in;
         for (int t = 1; t < TAPS; t++) tap_q[t] <= tap_q[t-1];
      end
   end

   for (genvar t = 0; t < TAPS; t++) begin : g_mul
      assign mul[t] = PROD_W'($signed(tap_q[t])) * PROD_W'($signed(coef[t]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_q <= '0;
      end else begin
         for (int t = 0; t < TAPS; t++) prod_q[t] <= mul[t];
      end
   end
endmodule

// File: rtl/casc_fir9_sumtree.sv
module casc_fir9_sumtree #(
   parameter int TAPS       = 9,
   parameter int PROD_W     = 22,
   parameter int ACC_W      = 27,
   parameter int GROUP      = 3,
   parameter bit SPLIT_TREE = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [TAPS-1:0][PROD_W-1:0]  prod,
   output logic signed [ACC_W-1:0]      total_q
);
   if (ACC_W < PROD_W + $clog2(TAPS) + 1) begin : g_bad_acc
      $error("accumulator width too small for the tap count");
   end

   if (SPLIT_TREE) begin : g_split
      localparam int NGRP = TAPS / GROUP;
      logic signed [ACC_W-1:0] grp_d [NGRP];
      logic signed [ACC_W-1:0] grp_q [NGRP];
      logic signed [ACC_W-1:0] all_d;

      if (TAPS % GROUP != 0) begin : g_bad_group
         $error("tap count must be a multiple of the group size");
      end

      always_comb begin
         for (int g = 0; g < NGRP; g++) begin
            grp_d[g] = '0;
            for (int k = 0; k < GROUP; k++) begin
               grp_d[g] = grp_d[g] + ACC_W'($signed(prod[g*GROUP + k]));
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int g = 0; g < NGRP; g++) grp_q[g] <= '0;
         end else begin
            for (int g = 0; g < NGRP; g++) grp_q[g] <= grp_d[g];
         end
      end

      always_comb begin
         all_d = '0;
         for (int g = 0; g < NGRP; g++) all_d = all_d + grp_q[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) total_q <= '0;
         else        total_q <= all_d;
      end
   end else begin : g_flat
      logic signed [ACC_W-1:0] full_d;
      logic signed [ACC_W-1:0] full_q;

      always_comb begin
         full_d = '0;
         for (int t = 0; t < TAPS; t++) full_d = full_d + ACC_W'($signed(prod[t]));
      end

      // the second stage only retimes, keeping the latency of the split tree
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            full_q  <= '0;
            total_q <= '0;
         end else begin
            full_q  <= full_d;
            total_q <= full_q;
         end
      end
   end
endmodule

// File: rtl/casc_fir9_casround.sv
module casc_fir9_casround #(
   parameter int CAS_W   = 16,
   parameter int ACC_W   = 27,
   parameter int ALIGN   = 5,
   parameter int CAS_PRE = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [CAS_W-1:0]         cascade_in,
   input  logic signed [ACC_W-1:0]  total,
   output logic [CAS_W-1:0]         cascade_out
);
   localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 << (ALIGN - 1));

   logic [CAS_W-1:0]        cas_pipe [CAS_PRE];
   logic signed [ACC_W-1:0] cas_al;
   logic signed [ACC_W-1:0] acc_q;

   if (ALIGN < 1) begin : g_bad_align
      $error("coefficient fraction must exceed the cascade fraction");
   end
   if (CAS_PRE < 1) begin : g_bad_pre
      $error("cascade path needs at least one capture register");
   end
   if (ACC_W < CAS_W + ALIGN + 1) begin : g_bad_acc
      $error("accumulator too narrow for the aligned cascade word");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cas_pipe[0] <= '0;
      else        cas_pipe[0] <= cascade_in;
   end

   for (genvar s = 1; s < CAS_PRE; s++) begin : g_cas_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cas_pipe[s] <= '0;
         else        cas_pipe[s] <= cas_pipe[s-1];
      end
   end

   assign cas_al = ACC_W'($signed(cas_pipe[CAS_PRE-1])) <<< ALIGN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q       <= '0;
         cascade_out <= '0;
      end else begin
         acc_q       <= total + cas_al;
         cascade_out <= CAS_W'((acc_q + HALF) >>> ALIGN);
      end
   end
endmodule

// File: rtl/casc_fir9.sv
module casc_fir9
   import casc_fir9_pkg::*;
#(
   parameter int TAPS       = 9,
   parameter int DATA_W     = 12,
   parameter int COEF_W     = 10,
   parameter int CAS_W      = 16,
   parameter int CAS_FRAC   = 4,
   parameter int GROUP      = 3,
   parameter bit SPLIT_TREE = 1'b1,
   localparam int ADDR_W    = $clog2(TAPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              coef_we,
   input  logic [ADDR_W-1:0] coef_addr,
   input  logic [COEF_W-1:0] coef_wdata,
   input  logic [DATA_W-1:0] sample_in,
   input  logic [CAS_W-1:0]  cascade_in,
   output logic [CAS_W-1:0]  cascade_out
);
   localparam int COEF_FRAC = COEF_W - 1;
   localparam int ALIGN     = COEF_FRAC - CAS_FRAC;
   localparam int PROD_W    = DATA_W + COEF_W;
   localparam int ACC_W     = acc_width(PROD_W, TAPS, CAS_W, ALIGN);
   localparam int CAS_PRE   = LAT_CASCADE - 1;

   if (TAPS < 2) begin : g_bad_taps
      $error("at least two taps are required");
   end
   if (CAS_FRAC >= COEF_FRAC) begin : g_bad_frac
      $error("cascade fraction must be narrower than the coefficient fraction");
   end

   logic [TAPS-1:0][COEF_W-1:0] coef_bus;
   logic                        coef_zero;
   logic [TAPS-1:0][PROD_W-1:0] prod_bus;
   logic signed [ACC_W-1:0]     total;

   casc_fir9_coef_bank #(
      .TAPS(TAPS), .COEF_W(COEF_W), .ADDR_W(ADDR_W)
   ) u_coef (
      .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_addr(coef_addr),
      .wr_data(coef_wdata), .coef_q(coef_bus), .coef_zero(coef_zero)
   );

   casc_fir9_tapline #(
      .TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W), .PROD_W(PROD_W)
   ) u_taps (
      .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .coef(coef_bus),
      .prod_q(prod_bus)
   );

   casc_fir9_sumtree #(
      .TAPS(TAPS), .PROD_W(PROD_W), .ACC_W(ACC_W), .GROUP(GROUP),
      .SPLIT_TREE(SPLIT_TREE)
   ) u_sum (
      .clk(clk), .rst_n(rst_n), .prod(prod_bus), .total_q(total)
   );

   casc_fir9_casround #(
      .CAS_W(CAS_W), .ACC_W(ACC_W), .ALIGN(ALIGN), .CAS_PRE(CAS_PRE)
   ) u_out (
      .clk(clk), .rst_n(rst_n), .cascade_in(cascade_in), .total(total),
      .cascade_out(cascade_out)
   );

   // run of consecutive edges with every coefficient zero, saturating at 7
   logic [2:0] zero_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                zero_run <= '0;
      else if (!coef_zero)       zero_run <= '0;
      else if (zero_run != 3'd7) zero_run <= zero_run + 3'd1;
   end

   // R1: output is clear on the first edge out of reset
   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cascade_out == '0));

   // R6: zero coefficients produce zero products
   assert_zero_coef_prod_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_run != 3'd0) |-> (prod_bus == '0));

   // R5: with the taps silent the cascade word passes through four edges later
   assert_cascade_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_run == 3'd7) |-> (cascade_out == $past(cascade_in, 5)));
endmodule

// File: tb/test_casc_fir9.sv
`timescale 1ns/1ps
module test_casc_fir9;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we_a = 1'b0;
   logic        we_b = 1'b0;
   logic [3:0]  coef_addr = '0;
   logic [9:0]  coef_wdata = '0;
   logic [11:0] sample_in = '0;
   logic [15:0] casc_in = '0;
   logic [15:0] out_a;
   logic [15:0] out_b;

   always #2.5 clk = ~clk;

   casc_fir9 i_casc_fir9 (
      .clk(clk), .rst_n(rst_n), .coef_we(we_a), .coef_addr(coef_addr),
      .coef_wdata(coef_wdata), .sample_in(sample_in), .cascade_in(casc_in),
      .cascade_out(out_a)
   );

   casc_fir9 i_casc_fir9_tail (
      .clk(clk), .rst_n(rst_n), .coef_we(we_b), .coef_addr(coef_addr),
      .coef_wdata(coef_wdata), .sample_in(sample_in), .cascade_in(out_a),
      .cascade_out(out_b)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   bit    model_on = 1'b1;
   string tag = "R1";

   int ha [9];
   int hb [9];
   int xs [16];
   int cs [8];
   int eas [8];
   logic [15:0] exp_a = '0;
   logic [15:0] exp_b = '0;

   task automatic chk(input string t, input logic [15:0] act, input logic [15:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", t, act, expv);
      end
   endtask

   function automatic int s16(input logic [15:0] v);
      return int'($signed(v));
   endfunction

   // one clock: drive inputs, advance the reference model, compare after the edge
   task automatic step(input int x, input int c);
      longint acc;
      sample_in = 12'(x);
      casc_in   = 16'(c);
      @(posedge clk);
      for (int j = 15; j > 0; j--) xs[j] = xs[j-1];
      xs[0] = x;
      for (int j = 7; j > 0; j--) cs[j] = cs[j-1];
      cs[0] = c;
      acc = 0;
      for (int i = 0; i < 9; i++) acc += longint'(ha[i]) * longint'(xs[5+i]);
      acc += longint'(cs[4]) * 32 + 16;
      exp_a = 16'(acc >>> 5);
      for (int j = 7; j > 0; j--) eas[j] = eas[j-1];
      eas[0] = s16(exp_a);
      acc = 0;
      for (int i = 0; i < 9; i++) acc += longint'(hb[i]) * longint'(xs[5+i]);
      acc += longint'(eas[5]) * 32 + 16;
      exp_b = 16'(acc >>> 5);
      @(negedge clk);
      if (model_on) begin
         chk(tag, out_a, exp_a);
         chk(tag, out_b, exp_b);
      end
   endtask

   task automatic flush();
      repeat (16) step(0, 0);
   endtask

   task automatic load(input bit to_b, input int addr, input int val);
      coef_addr  = 4'(addr);
      coef_wdata = 10'(val);
      if (to_b) we_b = 1'b1;
      else      we_a = 1'b1;
      step(0, 0);
      we_a = 1'b0;
      we_b = 1'b0;
      if (addr < 9) begin
         if (to_b) hb[addr] = int'($signed(10'(val)));
         else      ha[addr] = int'($signed(10'(val)));
      end
   endtask

   task automatic impulse_check(input string t);
      step(256, 0);
      chk(t, out_a, 16'h0000);
      for (int j = 1; j < 16; j++) begin
         step(0, 0);
         if (j >= 5 && j <= 13) chk(t, out_a, 16'(8 * ha[j-5]));
         else                   chk(t, out_a, 16'h0000);
      end
   endtask

   task automatic t_reset();
      tag = "R1";
      for (int i = 0; i < 9; i++) begin ha[i] = 0; hb[i] = 0; end
      for (int j = 0; j < 16; j++) xs[j] = 0;
      for (int j = 0; j < 8; j++) begin cs[j] = 0; eas[j] = 0; end
      sample_in = 12'h7FF;
      casc_in   = 16'h1234;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", out_a, 16'h0000);
      chk("R1", out_b, 16'h0000);
      sample_in = '0;
      casc_in   = '0;
      rst_n = 1'b1;
      step(0, 0);
      chk("R1", out_a, 16'h0000);
      flush();
   endtask

   task automatic t_impulse();
      int vals [9] = '{511, -512, 1, -1, 100, -100, 37, 0, 255};
      tag = "R2";
      for (int i = 0; i < 9; i++) load(1'b0, i, vals[i]);
      flush();
      tag = "R4";
      impulse_check("R4 R2 impulse");
   endtask

   task automatic t_far_addr();
      tag = "R3";
      for (int a = 9; a < 16; a++) load(1'b0, a, 10'h1AB);
      flush();
      impulse_check("R3 far address");
   endtask

   task automatic t_cascade();
      tag = "R5";
      for (int i = 0; i < 9; i++) load(1'b0, i, 0);
      flush();
      step(0, 16'h1234);
      chk("R5", out_a, 16'h0000);
      step(0, s16(16'h8001));
      for (int j = 2; j < 10; j++) begin
         step(0, 0);
         if (j == 4)      chk("R5 cascade latency", out_a, 16'h1234);
         else if (j == 5) chk("R5 cascade latency", out_a, 16'h8001);
         else             chk("R5 cascade latency", out_a, 16'h0000);
      end
      flush();
   endtask

   task automatic t_round();
      int          xv [5] = '{16, 15, -16, -17, 48};
      logic [15:0] ev [5] = '{16'h0001, 16'h0000, 16'h0000, 16'hFFFF, 16'h0002};
      tag = "R6";
      load(1'b0, 0, 1);
      flush();
      for (int s = 0; s < 11; s++) begin
         step((s < 5) ? xv[s] : 0, 0);
         if (s >= 5 && s < 10) chk("R6 half-LSB", out_a, ev[s-5]);
      end
      flush();
   endtask

   task automatic t_coarse();
      tag = "R7";
      load(1'b0, 0, 256);
      flush();
      // +0.5 from the tap plus the half-weight cascade bit: rounds up to 1
      step(1, 0);
      step(0, 8);
      repeat (4) step(0, 0);
      chk("R7 coarse", {4'h0, out_a[15:4]}, 16'h0001);
      // -0.5 plus the half-weight bit: rounds to 0
      step(-1, 0);
      step(0, 8);
      repeat (4) step(0, 0);
      chk("R7 coarse", {4'h0, out_a[15:4]}, 16'h0000);
      // without the cascade bit the same +0.5 stays below the integer LSB
      step(1, 0);
      repeat (5) step(0, 0);
      chk("R7 coarse", {4'h0, out_a[15:4]}, 16'h0000);
      flush();
   endtask

   task automatic t_wrap();
      tag = "R8";
      for (int i = 0; i < 9; i++) load(1'b0, i, 511);
      flush();
      repeat (14) step(2047, 0);
      chk("R8 wrap", out_a, exp_a);
      repeat (4) step(2047, s16(16'h7FF0));
      repeat (4) step(-2048, s16(16'h8000));
      repeat (16) step(0, 0);
      flush();
   endtask

   task automatic t_stream();
      tag = "R9";
      for (int i = 0; i < 9; i++) load(1'b0, i, int'($signed(10'($urandom))));
      flush();
      for (int s = 0; s < 80; s++)
         step(int'($signed(12'($urandom))), int'($signed(16'($urandom))));
      repeat (16) step(0, 0);
   endtask

   task automatic t_chain();
      tag = "R10";
      for (int i = 0; i < 9; i++) load(1'b1, i, int'($signed(10'($urandom))));
      flush();
      for (int s = 0; s < 80; s++)
         step(int'($signed(12'($urandom))), int'($signed(16'($urandom))));
      repeat (16) step(0, 0);
   endtask

   initial begin
      #750000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_impulse();
      t_far_addr();
      t_cascade();
      t_round();
      t_coarse();
      t_wrap();
      t_stream();
      t_chain();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule